// File: doc/BRIEF.md
# Two-Stage Virtual Channel Allocator

This block hands out virtual channels (VCs) to packet headers in a five-port on-chip router. Every input port buffers up to sixteen header slots. Each slot can raise a request for a VC on the output port that the route logic has already computed for it. Each cycle, a first arbitration stage picks one requesting slot per (input, output) pair. A second stage then picks one input per output. A token dispenser on each output chooses the lowest-numbered free VC. The winner is written directly into registers inside the allocator, and no separate combinational control unit sits between arbitration and the state. Those registers are a per-slot control table, which records that the slot owns a VC and which output/VC pair it owns, and a per-output busy map of VCs.

The switch allocator reads the table and the busy map from the allocator's outputs. When a packet's tail leaves, the owning input port raises a release naming the slot. At the next clock edge the table entry is cleared and the VC is returned. A request that finds no free VC on its output is simply not granted. The requester keeps it raised and it competes again in the following cycle.

Top module: `vc_alloc2s`

## Requirements
- R1: After synchronous reset, no grant is valid, every table entry is invalid and every VC of every output is free.
- R2: A request sampled at a clock edge that wins produces, in the following cycle, gnt_vld[o]=1 with the input index, slot index and VC on that output's grant fields. In the same cycle the table entry (input*16+slot) shows valid, port o and that VC, and vc_busy bit o*4+vc is 1.
- R3: Among the slots of one input that request the same output, the lowest slot index wins, and no two outputs grant the same slot in one cycle.
- R4: Among the inputs whose first-stage winners target the same output, the lowest input index wins.
- R5: The token dispenser grants the lowest-numbered free VC of the output.
- R6: When all four VCs of an output are busy, that output grants nothing. The waiting request is granted once a VC frees up.
- R7: A release takes effect at the clock edge that samples it. A request to a full output sampled at that same edge is not granted, and it can be granted at the next edge.
- R8: No output grants a VC that is already busy. The number of busy VCs always equals the number of valid table entries.
- R9: A request from a slot that already owns a VC is ignored: no further grant appears for it.
- R10: A request whose output code is 5, 6 or 7 (no such port) is ignored and creates no grant and no table entry.
- R11: Different outputs grant independently in the same cycle, up to five grants per cycle.
- R12: A release naming a slot with no valid table entry is ignored: the busy map and the table are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Router clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 80 | Request bit per slot, entry index input*16+slot |
| req_port | input | 240 | 3-bit output port code per slot, same entry order |
| rel_vld | input | 5 | Release strobe per input port |
| rel_slot | input | 20 | 4-bit slot index per input port to release |
| gnt_vld | output | 5 | Grant valid per output port |
| gnt_in | output | 15 | 3-bit winning input index per output |
| gnt_slot | output | 20 | 4-bit winning slot index per output |
| gnt_vc | output | 10 | 2-bit VC granted per output |
| tbl_vld | output | 80 | Control table: slot owns a VC |
| tbl_port | output | 240 | Control table: output port owned, 3 bits per slot |
| tbl_vc | output | 160 | Control table: VC owned, 2 bits per slot |
| vc_busy | output | 20 | Availability map, bit output*4+vc |

## Verification
A sweep over all twenty-five input/output pairs with a lone request shows that each pair is wired correctly. It also covers the grant-to-table path and the way a held request is masked. Sixteen slots of one input flooding one output separate first-stage priority from token order. The flood also exhausts the VCs, and a release in the same cycle then shows the one-cycle delay before a freed VC can be granted again. Five inputs contending for one output isolate the second stage. Five inputs on five distinct outputs, bad port codes and stray releases show that outputs work independently and that bogus stimulus is ignored.

// File: rtl/vca_pkg.sv
package vca_pkg;

    localparam int unsigned DEF_PORTS = 5;
    localparam int unsigned DEF_SLOTS = 16;
    localparam int unsigned DEF_VCS   = 4;

    // index width for a set of n items, never below one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vca_prio_arb.sv
module vca_prio_arb #(
    parameter  int unsigned N  = 16,
    localparam int unsigned IW = vca_pkg::idx_w(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // fixed priority: lowest index wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                hit = 1'b1;
                idx = IW'(k);
            end
        end
    end

endmodule

// File: rtl/vca_token.sv
module vca_token #(
    parameter  int unsigned NVC = 4,
    localparam int unsigned VW  = vca_pkg::idx_w(NVC)
) (
    input  logic [NVC-1:0] busy,
    output logic           free_any,
    output logic [VW-1:0]  vc
);

    logic [NVC-1:0] free_map;

    assign free_map = ~busy;

    vca_prio_arb #(.N(NVC)) u_pick (
        .req (free_map),
        .hit (free_any),
        .idx (vc)
    );

endmodule

// File: rtl/vca_stage1.sv
module vca_stage1 #(
    parameter  int unsigned NPORT = 5,
    parameter  int unsigned NSLOT = 16,
    localparam int unsigned PW    = vca_pkg::idx_w(NPORT),
    localparam int unsigned SW    = vca_pkg::idx_w(NSLOT),
    localparam int unsigned NENT  = NPORT * NSLOT,
    localparam int unsigned NPAIR = NPORT * NPORT
) (
    input  logic [NENT-1:0]     req,
    input  logic [NENT*PW-1:0]  req_port,
    input  logic [NENT-1:0]     held,
    output logic [NPAIR-1:0]    s1_hit,
    output logic [NPAIR*SW-1:0] s1_slot
);

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        for (genvar go = 0; go < NPORT; go++) begin : g_out
            logic [NSLOT-1:0] cand;

            // eligible: requesting, not already owning a VC, aimed at this output
            always_comb begin
                for (int s = 0; s < NSLOT; s++) begin
                    cand[s] = req[gi*NSLOT + s] & ~held[gi*NSLOT + s] &
                              (req_port[(gi*NSLOT + s)*PW +: PW] == PW'(go));
                end
            end

            vca_prio_arb #(.N(NSLOT)) u_arb (
                .req (cand),
                .hit (s1_hit[gi*NPORT + go]),
                .idx (s1_slot[(gi*NPORT + go)*SW +: SW])
            );
        end
    end

endmodule

// File: rtl/vca_stage2.sv
module vca_stage2 #(
    parameter  int unsigned NPORT = 5,
    parameter  int unsigned NSLOT = 16,
    parameter  int unsigned NVC   = 4,
    localparam int unsigned PW    = vca_pkg::idx_w(NPORT),
    localparam int unsigned SW    = vca_pkg::idx_w(NSLOT),
    localparam int unsigned VW    = vca_pkg::idx_w(NVC),
    localparam int unsigned NPAIR = NPORT * NPORT
) (
    input  logic [NPAIR-1:0]     s1_hit,
    input  logic [NPAIR*SW-1:0]  s1_slot,
    input  logic [NPORT*NVC-1:0] busy,
    output logic [NPORT-1:0]     win_vld,
    output logic [NPORT*PW-1:0]  win_in,
    output logic [NPORT*SW-1:0]  win_slot,
    output logic [NPORT*VW-1:0]  win_vc
);

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        logic [NPORT-1:0] cand;
        logic             any_in;
        logic [PW-1:0]    pick_in;
        logic             free_any;

        always_comb begin
            for (int i = 0; i < NPORT; i++) begin
                cand[i] = s1_hit[i*NPORT + go];
            end
        end

        vca_prio_arb #(.N(NPORT)) u_arb (
            .req (cand),
            .hit (any_in),
            .idx (pick_in)
        );

        vca_token #(.NVC(NVC)) u_tok (
            .busy     (busy[go*NVC +: NVC]),
            .free_any (free_any),
            .vc       (win_vc[go*VW +: VW])
        );

        // forward the slot picked by the first stage of the winning input
        always_comb begin
            win_slot[go*SW +: SW] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (pick_in == PW'(i)) begin
                    win_slot[go*SW +: SW] = s1_slot[(i*NPORT + go)*SW +: SW];
                end
            end
        end

        assign win_vld[go]          = any_in & free_any;
        assign win_in[go*PW +: PW]  = pick_in;
    end

endmodule

// File: rtl/vca_table.sv
module vca_table #(
    parameter  int unsigned NPORT = 5,
    parameter  int unsigned NSLOT = 16,
    parameter  int unsigned NVC   = 4,
    localparam int unsigned PW    = vca_pkg::idx_w(NPORT),
    localparam int unsigned SW    = vca_pkg::idx_w(NSLOT),
    localparam int unsigned VW    = vca_pkg::idx_w(NVC),
    localparam int unsigned NENT  = NPORT * NSLOT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPORT-1:0]     win_vld,
    input  logic [NPORT*PW-1:0]  win_in,
    input  logic [NPORT*SW-1:0]  win_slot,
    input  logic [NPORT*VW-1:0]  win_vc,
    input  logic [NPORT-1:0]     rel_vld,
    input  logic [NPORT*SW-1:0]  rel_slot,
    output logic [NPORT-1:0]     gnt_vld,
    output logic [NPORT*PW-1:0]  gnt_in,
    output logic [NPORT*SW-1:0]  gnt_slot,
    output logic [NPORT*VW-1:0]  gnt_vc,
    output logic [NENT-1:0]      tbl_vld,
    output logic [NENT*PW-1:0]   tbl_port,
    output logic [NENT*VW-1:0]   tbl_vc,
    output logic [NPORT*NVC-1:0] vc_busy
);

    logic [NENT-1:0]      vld_q,  vld_n;
    logic [NENT*PW-1:0]   port_q, port_n;
    logic [NENT*VW-1:0]   vc_q,   vc_n;
    logic [NPORT*NVC-1:0] busy_q, busy_n;

    always_comb begin
        int e;
        int b;
        e      = 0;
        b      = 0;
        vld_n  = vld_q;
        port_n = port_q;
        vc_n   = vc_q;
        busy_n = busy_q;

        // releases: clear the entry and return its VC
        for (int i = 0; i < NPORT; i++) begin
            e = i*NSLOT + int'(rel_slot[i*SW +: SW]);
            if (rel_vld[i] && e < int'(NENT) && vld_q[e]) begin
                vld_n[e] = 1'b0;
                b = int'(port_q[e*PW +: PW])*NVC + int'(vc_q[e*VW +: VW]);
                if (b < int'(NPORT*NVC)) begin
                    busy_n[b] = 1'b0;
                end
            end
        end

        // allocations: record owner and mark the VC taken
        for (int o = 0; o < NPORT; o++) begin
            e = int'(win_in[o*PW +: PW])*NSLOT + int'(win_slot[o*SW +: SW]);
            if (win_vld[o] && e < int'(NENT)) begin
                vld_n[e]             = 1'b1;
                port_n[e*PW +: PW]   = PW'(o);
                vc_n[e*VW +: VW]     = win_vc[o*VW +: VW];
                busy_n[o*NVC + int'(win_vc[o*VW +: VW])] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= '0;
            port_q   <= '0;
            vc_q     <= '0;
            busy_q   <= '0;
            gnt_vld  <= '0;
            gnt_in   <= '0;
            gnt_slot <= '0;
            gnt_vc   <= '0;
        end else begin
            vld_q    <= vld_n;
            port_q   <= port_n;
            vc_q     <= vc_n;
            busy_q   <= busy_n;
            gnt_vld  <= win_vld;
            gnt_in   <= win_in;
            gnt_slot <= win_slot;
            gnt_vc   <= win_vc;
        end
    end

    assign tbl_vld  = vld_q;
    assign tbl_port = port_q;
    assign tbl_vc   = vc_q;
    assign vc_busy  = busy_q;

endmodule

// File: rtl/vc_alloc2s.sv
module vc_alloc2s #(
    parameter  int unsigned NPORT = vca_pkg::DEF_PORTS,
    parameter  int unsigned NSLOT = vca_pkg::DEF_SLOTS,
    parameter  int unsigned NVC   = vca_pkg::DEF_VCS,
    localparam int unsigned PW    = vca_pkg::idx_w(NPORT),
    localparam int unsigned SW    = vca_pkg::idx_w(NSLOT),
    localparam int unsigned VW    = vca_pkg::idx_w(NVC),
    localparam int unsigned NENT  = NPORT * NSLOT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NENT-1:0]      req,
    input  logic [NENT*PW-1:0]   req_port,
    input  logic [NPORT-1:0]     rel_vld,
    input  logic [NPORT*SW-1:0]  rel_slot,
    output logic [NPORT-1:0]     gnt_vld,
    output logic [NPORT*PW-1:0]  gnt_in,
    output logic [NPORT*SW-1:0]  gnt_slot,
    output logic [NPORT*VW-1:0]  gnt_vc,
    output logic [NENT-1:0]      tbl_vld,
    output logic [NENT*PW-1:0]   tbl_port,
    output logic [NENT*VW-1:0]   tbl_vc,
    output logic [NPORT*NVC-1:0] vc_busy
);

    localparam int unsigned NPAIR = NPORT * NPORT;

    logic [NPAIR-1:0]    s1_hit;
    logic [NPAIR*SW-1:0] s1_slot;
    logic [NPORT-1:0]    win_vld;
    logic [NPORT*PW-1:0] win_in;
    logic [NPORT*SW-1:0] win_slot;
    logic [NPORT*VW-1:0] win_vc;

    vca_stage1 #(.NPORT(NPORT), .NSLOT(NSLOT)) u_s1 (
        .req      (req),
        .req_port (req_port),
        .held     (tbl_vld),
        .s1_hit   (s1_hit),
        .s1_slot  (s1_slot)
    );

    vca_stage2 #(.NPORT(NPORT), .NSLOT(NSLOT), .NVC(NVC)) u_s2 (
        .s1_hit   (s1_hit),
        .s1_slot  (s1_slot),
        .busy     (vc_busy),
        .win_vld  (win_vld),
        .win_in   (win_in),
        .win_slot (win_slot),
        .win_vc   (win_vc)
    );

    vca_table #(.NPORT(NPORT), .NSLOT(NSLOT), .NVC(NVC)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .win_vld  (win_vld),
        .win_in   (win_in),
        .win_slot (win_slot),
        .win_vc   (win_vc),
        .rel_vld  (rel_vld),
        .rel_slot (rel_slot),
        .gnt_vld  (gnt_vld),
        .gnt_in   (gnt_in),
        .gnt_slot (gnt_slot),
        .gnt_vc   (gnt_vc),
        .tbl_vld  (tbl_vld),
        .tbl_port (tbl_port),
        .tbl_vc   (tbl_vc),
        .vc_busy  (vc_busy)
    );

endmodule

// File: rtl/vc_alloc2s_chk.sv
module vc_alloc2s_chk #(
    parameter  int unsigned NPORT = 5,
    parameter  int unsigned NSLOT = 16,
    parameter  int unsigned NVC   = 4,
    localparam int unsigned PW    = vca_pkg::idx_w(NPORT),
    localparam int unsigned SW    = vca_pkg::idx_w(NSLOT),
    localparam int unsigned VW    = vca_pkg::idx_w(NVC),
    localparam int unsigned NENT  = NPORT * NSLOT
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NPORT-1:0]     gnt_vld,
    input logic [NPORT*PW-1:0]  gnt_in,
    input logic [NPORT*SW-1:0]  gnt_slot,
    input logic [NPORT*VW-1:0]  gnt_vc,
    input logic [NENT-1:0]      tbl_vld,
    input logic [NENT*PW-1:0]   tbl_port,
    input logic [NENT*VW-1:0]   tbl_vc,
    input logic [NPORT*NVC-1:0] vc_busy
);

    logic [NPORT*NVC-1:0] busy_d;
    logic [NPORT-1:0]     tbl_ok;
    logic [NPORT-1:0]     was_free;
    logic                 dup;

    always_ff @(posedge clk) begin
        if (rst) busy_d <= '0;
        else     busy_d <= vc_busy;
    end

    always_comb begin
        int e;
        int b;
        e   = 0;
        b   = 0;
        dup = 1'b0;
        for (int o = 0; o < NPORT; o++) begin
            e = int'(gnt_in[o*PW +: PW])*NSLOT + int'(gnt_slot[o*SW +: SW]);
            b = o*NVC + int'(gnt_vc[o*VW +: VW]);
            tbl_ok[o]   = (e < int'(NENT)) && tbl_vld[e] &&
                          (tbl_port[e*PW +: PW] == PW'(o)) &&
                          (tbl_vc[e*VW +: VW] == gnt_vc[o*VW +: VW]) && vc_busy[b];
            was_free[o] = !busy_d[b];
        end
        for (int a = 0; a < NPORT; a++) begin
            for (int c = a + 1; c < NPORT; c++) begin
                if (gnt_vld[a] && gnt_vld[c] &&
                    gnt_in[a*PW +: PW] == gnt_in[c*PW +: PW] &&
                    gnt_slot[a*SW +: SW] == gnt_slot[c*SW +: SW]) begin
                    dup = 1'b1;
                end
            end
        end
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        p_grant_logged_r2: assert property (@(posedge clk) disable iff (rst)
            gnt_vld[go] |-> tbl_ok[go]);
        p_vc_was_free_r8: assert property (@(posedge clk) disable iff (rst)
            gnt_vld[go] |-> was_free[go]);
    end

    p_tracer_matches_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(vc_busy) == $countones(tbl_vld));

    p_unique_entry_r3: assert property (@(posedge clk) disable iff (rst)
        !dup);

endmodule

bind vc_alloc2s vc_alloc2s_chk #(.NPORT(NPORT), .NSLOT(NSLOT), .NVC(NVC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gnt_vld  (gnt_vld),
    .gnt_in   (gnt_in),
    .gnt_slot (gnt_slot),
    .gnt_vc   (gnt_vc),
    .tbl_vld  (tbl_vld),
    .tbl_port (tbl_port),
    .tbl_vc   (tbl_vc),
    .vc_busy  (vc_busy)
);

// File: tb/vc_alloc2s_test.sv
`timescale 1ns/1ps
module vc_alloc2s_test;

    localparam int NP = 5, NS = 16, NV = 4, PW = 3, SW = 4, VW = 2;
    localparam int NE = NP * NS;

    logic            clk = 1'b0;
    logic            rst;
    logic [NE-1:0]   req;
    logic [NE*PW-1:0] req_port;
    logic [NP-1:0]   rel_vld;
    logic [NP*SW-1:0] rel_slot;
    logic [NP-1:0]   gnt_vld;
    logic [NP*PW-1:0] gnt_in;
    logic [NP*SW-1:0] gnt_slot;
    logic [NP*VW-1:0] gnt_vc;
    logic [NE-1:0]   tbl_vld;
    logic [NE*PW-1:0] tbl_port;
    logic [NE*VW-1:0] tbl_vc;
    logic [NP*NV-1:0] vc_busy;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vc_alloc2s uut (
        .clk(clk), .rst(rst), .req(req), .req_port(req_port),
        .rel_vld(rel_vld), .rel_slot(rel_slot),
        .gnt_vld(gnt_vld), .gnt_in(gnt_in), .gnt_slot(gnt_slot), .gnt_vc(gnt_vc),
        .tbl_vld(tbl_vld), .tbl_port(tbl_port), .tbl_vc(tbl_vc), .vc_busy(vc_busy)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_req(input int i, input int s, input int p, input bit on);
        req[i*NS + s] = on;
        req_port[(i*NS + s)*PW +: PW] = PW'(p);
    endtask

    task automatic release_slot(input int i, input int s);
        rel_vld[i] = 1'b1;
        rel_slot[i*SW +: SW] = SW'(s);
    endtask

    task automatic chk_gnt(input string tag, input int o, input int i, input int s, input int v);
        chk({tag, " gnt_vld"},  gnt_vld[o], 1);
        chk({tag, " gnt_in"},   gnt_in[o*PW +: PW], i);
        chk({tag, " gnt_slot"}, gnt_slot[o*SW +: SW], s);
        chk({tag, " gnt_vc"},   gnt_vc[o*VW +: VW], v);
    endtask

    task automatic chk_entry(input string tag, input int i, input int s, input int o, input int v);
        chk({tag, " tbl_vld"},  tbl_vld[i*NS + s], 1);
        chk({tag, " tbl_port"}, tbl_port[(i*NS + s)*PW +: PW], o);
        chk({tag, " tbl_vc"},   tbl_vc[(i*NS + s)*VW +: VW], v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst      = 1'b1;
        req      = '0;
        req_port = '0;
        rel_vld  = '0;
        rel_slot = '0;
        repeat (4) cyc();
        rst = 1'b0;
        cyc();

        // R1: reset state
        chk("R1 gnt_vld", gnt_vld, 0);
        chk("R1 tbl_vld", tbl_vld, 0);
        chk("R1 vc_busy", vc_busy, 0);

        // R2/R9: every input/output pair alone
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                int s;
                s = (i*3 + o) % NS;
                set_req(i, s, o, 1'b1);
                cyc();
                chk_gnt("R2 pair", o, i, s, 0);
                chk("R2 other outputs", gnt_vld & ~(5'(1) << o), 0);
                chk_entry("R2 pair", i, s, o, 0);
                chk("R2 busy", vc_busy, longint'(1) << (o*NV));
                cyc();
                chk("R9 held request ignored", gnt_vld, 0);
                set_req(i, s, 0, 1'b0);
                release_slot(i, s);
                cyc();
                rel_vld = '0;
                chk("R2 release clears entry", tbl_vld, 0);
                chk("R2 release frees vc", vc_busy, 0);
            end
        end

        // R3/R5/R6/R7/R8: sixteen slots of input 2 flood output 3
        for (int s = 0; s < NS; s++) set_req(2, s, 3, 1'b1);
        for (int k = 0; k < NV; k++) begin
            cyc();
            chk_gnt("R3 R5 flood", 3, 2, k, k);
        end
        cyc();
        chk("R6 full output grants nothing", gnt_vld, 0);
        chk("R8 four distinct vcs busy", vc_busy[3*NV +: NV], 4'hF);
        set_req(2, 1, 3, 1'b0);
        release_slot(2, 1);
        cyc();
        rel_vld = '0;
        chk("R7 same-cycle release not granted", gnt_vld, 0);
        chk("R7 vc1 freed", vc_busy[3*NV +: NV], 4'hD);
        cyc();
        chk_gnt("R5 R6 lowest free vc after release", 3, 2, 4, 1);
        for (int s = 0; s < NS; s++) set_req(2, s, 0, 1'b0);
        for (int k = 0; k < 5; k++) begin
            if (k != 1) begin
                release_slot(2, k);
                cyc();
            end
        end
        rel_vld = '0;
        cyc();
        chk("R8 flood drained busy", vc_busy, 0);
        chk("R8 flood drained table", tbl_vld, 0);

        // R4: slot 5 of all inputs contend for output 1
        for (int i = 0; i < NP; i++) set_req(i, 5, 1, 1'b1);
        for (int k = 0; k < NV; k++) begin
            cyc();
            chk_gnt("R4 lowest input wins", 1, k, 5, k);
        end
        cyc();
        chk("R4 R6 input 4 waits", gnt_vld, 0);
        set_req(0, 5, 0, 1'b0);
        release_slot(0, 5);
        cyc();
        rel_vld = '0;
        chk("R7 release then wait", gnt_vld, 0);
        cyc();
        chk_gnt("R4 R6 input 4 served", 1, 4, 5, 0);
        for (int i = 0; i < NP; i++) set_req(i, 5, 0, 1'b0);
        for (int i = 1; i < NP; i++) release_slot(i, 5);
        cyc();
        rel_vld = '0;
        chk("R11 parallel releases", vc_busy, 0);

        // R11: five outputs in one cycle
        for (int i = 0; i < NP; i++) set_req(i, 7, i, 1'b1);
        cyc();
        for (int o = 0; o < NP; o++) chk_gnt("R11 parallel", o, o, 7, 0);
        for (int i = 0; i < NP; i++) set_req(i, 7, 0, 1'b0);

        // R12: stray release
        release_slot(1, 9);
        cyc();
        rel_vld = '0;
        chk("R12 busy unchanged", vc_busy, 20'h11111);
        chk("R12 table unchanged", tbl_vld, 80'h0080_0080_0080_0080_0080);

        // R10: illegal port codes
        set_req(3, 0, 5, 1'b1);
        set_req(3, 1, 6, 1'b1);
        set_req(3, 2, 7, 1'b1);
        cyc();
        cyc();
        chk("R10 no grant", gnt_vld, 0);
        chk("R10 no entry", tbl_vld[3*NS +: 3], 0);
        chk("R10 busy unchanged", vc_busy, 20'h11111);
        for (int s = 0; s < 3; s++) set_req(3, s, 0, 1'b0);

        for (int i = 0; i < NP; i++) release_slot(i, 7);
        cyc();
        rel_vld = '0;
        chk("R12 final busy clear", vc_busy, 0);
        chk("R12 final table clear", tbl_vld, 0);

        cyc();
        finish_run();
    end

endmodule